// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Detector

This block watches a six-pin input port for changes and raises a sticky port-change flag when any watched pin differs from a reference copy of the port. The reference copy is not the previous clock's value: it is a snapshot taken whenever software reads or writes the port register. A per-pin mask register chooses which pins take part in the comparison. Pin inputs are first passed through a two-flop synchroniser, and both the comparison and the snapshot use the synchronised values.

While a difference against the snapshot persists, the flag is set again on every clock. A clear of the flag therefore only lasts once software has accessed the port, which refreshes the snapshot and ends the difference. The flag drives a wake request directly, whatever the interrupt gate says. It also drives an interrupt output that is gated by a global enable bit. A pin that changes in the very cycle of a port access may be absorbed into the new snapshot without setting the flag.

Top module: `ioc_port_watch`

## Requirements
- R1: A pin whose mask bit is 1 is watched; a pin whose mask bit is 0 never sets the flag, whatever its level does.
- R2: The mask register sits at address 1, with the pin enables in bits 5:0. Bits 7:6 read back as 0 whatever was written to them.
- R3: After synchronous reset, the mask, the flag and the global enable read 0. No flag appears when the mask is later opened on pins that kept their reset-time levels.
- R4: A pin change applied before clock edge n shows in the flag after edge n+2. It is not visible after edge n+1.
- R5: A masked-in pin that differs from the snapshot sets the flag. A flag clear written while the difference persists leaves the flag at 1.
- R6: A read or a write at address 0 (the port) takes a new snapshot from the synchronised pins. A read at address 0 returns those pins in bits 5:0 and 0 in bits 7:6.
- R7: At the control register (address 2), writing 0 to bit 0 clears the flag once no difference exists. Writing 1 to bit 0 never sets it.
- R8: The flag stays at 1 after the pins return to the snapshot value, until it is cleared. The flag reads back in control bit 0.
- R9: `wake_o` equals the flag regardless of the global enable.
- R10: `irq_o` is 1 only when the flag is 1 and the global enable is 1. The global enable is control bit 1 and reads back there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Asynchronous port pin levels |
| addr | input | 2 | Register address: 0 port, 1 mask, 2 control |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of the port takes a snapshot) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| wake_o | output | 1 | Wake request, follows the flag |
| irq_o | output | 1 | Interrupt request, flag gated by the global enable |

## Verification
A stale or wrong snapshot shows at the ports as a flag that rises three edges after a mask change or a port access, with the pins held still. It can also show as a flag that cannot be cleared after a port access. A wrong mask bit makes a pin change either set the flag or fail to set it, and this is visible on `wake_o` within three clock edges. Gating errors show immediately on `irq_o` compared with the control readback.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int NPINS  = 6;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PORT = 2'd0,
        ADR_MASK = 2'd1,
        ADR_CTRL = 2'd2,
        ADR_NONE = 2'd3
    } ioc_addr_e;

    // Control register layout (bit positions are software-visible)
    localparam int CTRL_FLAG_BIT = 0;
    localparam int CTRL_GATE_BIT = 1;

    typedef struct packed {
        logic gate;   // global interrupt enable
        logic flag;   // sticky port-change flag
    } ioc_ctrl_t;

    // Per-pin difference against the snapshot, limited to watched pins
    function automatic logic [NPINS-1:0] pin_diff(
        input logic [NPINS-1:0] now_v,
        input logic [NPINS-1:0] snap_v,
        input logic [NPINS-1:0] mask_v
    );
        return (now_v ^ snap_v) & mask_v;
    endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    // Two flop stages per pin; no reset so pins settle during reset
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic st1, st2;
        always_ff @(posedge clk) begin
            st1 <= async_i[g];
            st2 <= st1;
        end
        assign sync_o[g] = st2;
    end
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect
    import ioc_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] mask,
    input  logic         snap_load,
    output logic [W-1:0] snap,
    output logic         hit
);
    logic [W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst || snap_load) snap <= pins_s;
    end

    assign diff = pin_diff(pins_s, snap, mask);
    // A difference seen during the snapshot cycle is absorbed into the new copy
    assign hit  = (|diff) && !snap_load;

    AST_SNAP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        snap_load |=> snap == $past(pins_s)) else $error("snapshot not taken"); // R6
endmodule

// File: rtl/ioc_regs.sv
module ioc_regs
    import ioc_pkg::*;
#(
    parameter int W  = NPINS,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  pins_s,
    input  logic          hit,
    output logic [W-1:0]  mask,
    output ioc_ctrl_t     ctrl,
    output logic          port_access,
    output logic [DW-1:0] rdata
);
    ioc_addr_e a;
    logic      ctrl_wr, flag_clr;
    logic      unused_wdata;

    assign a           = ioc_addr_e'(addr);
    assign port_access = (wr_en || rd_en) && (a == ADR_PORT);
    assign ctrl_wr     = wr_en && (a == ADR_CTRL);
    assign flag_clr    = ctrl_wr && !wdata[CTRL_FLAG_BIT];
    assign unused_wdata = ^wdata[DW-1:W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            ctrl <= '0;
        end else begin
            if (wr_en && a == ADR_MASK) mask <= wdata[W-1:0];
            if (ctrl_wr) ctrl.gate <= wdata[CTRL_GATE_BIT];
            // Difference re-sets the flag every cycle; set wins over clear
            ctrl.flag <= hit || (ctrl.flag && !flag_clr);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (a)
            ADR_PORT: rdata[W-1:0] = pins_s;
            ADR_MASK: rdata[W-1:0] = mask;
            ADR_CTRL: begin
                rdata[CTRL_FLAG_BIT] = ctrl.flag;
                rdata[CTRL_GATE_BIT] = ctrl.gate;
            end
            default:  rdata = '0;
        endcase
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[DW-1:W] == '0) else $error("upper bits nonzero"); // R2
    AST_RESET_MASK: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (mask == '0 && ctrl == '0)) else $error("reset state"); // R3
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctrl.flag) else $error("flag not set"); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !hit) |=> !ctrl.flag) else $error("clear lost"); // R7
    AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flag && !ctrl_wr) |=> ctrl.flag) else $error("flag dropped"); // R8
endmodule

// File: rtl/ioc_port_watch.sv
module ioc_port_watch
    import ioc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wake_o,
    output logic              irq_o
);
    logic [NPINS-1:0] pins_s, mask, snap;
    logic             hit, port_access;
    ioc_ctrl_t        ctrl;

    ioc_sync #(.W(NPINS)) u_sync (
        .clk(clk), .async_i(pin_i), .sync_o(pins_s)
    );

    ioc_detect #(.W(NPINS)) u_detect (
        .clk(clk), .rst(rst), .pins_s(pins_s), .mask(mask),
        .snap_load(port_access), .snap(snap), .hit(hit)
    );

    ioc_regs #(.W(NPINS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .pins_s(pins_s), .hit(hit), .mask(mask),
        .ctrl(ctrl), .port_access(port_access), .rdata(rdata)
    );

    assign wake_o = ctrl.flag;
    assign irq_o  = ctrl.flag && ctrl.gate;

    AST_WAKE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        wake_o == ctrl.flag) else $error("wake mismatch"); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ctrl.gate && wake_o)) else $error("irq ungated"); // R10
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.flag && mask == '0) |=> !ctrl.flag) else $error("masked set"); // R1
endmodule

// File: tb/tb_ioc_port_watch.sv
module tb_ioc_port_watch;
    import ioc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NPINS-1:0]  pin_i = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              wake_o, irq_o;

    int nvec = 0, nbad = 0, cyc = 0;
    logic done = 1'b0;

    // bench model
    logic [NPINS-1:0] m_pins = '0, m_snap = '0, m_mask = '0;
    logic             m_flag = 1'b0, m_gate = 1'b0;

    ioc_port_watch dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .wake_o(wake_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nbad + 1);
            $finish;
        end
    end

    function automatic logic diff_now();
        return |((m_pins ^ m_snap) & m_mask);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [NPINS-1:0] v);
        @(negedge clk);
        pin_i = v; m_pins = v;
        cycles(4);
        m_flag = m_flag | diff_now();
    endtask

    task automatic check_outs(input string req);
        logic [7:0] d;
        chk({req, " wake"}, wake_o, m_flag);
        chk({req, " irq"}, irq_o, m_flag & m_gate);
        bus_rd(ADR_CTRL, d);
        chk({req, " ctrl"}, d, {6'b0, m_gate, m_flag});
    endtask

    task automatic port_access(input logic do_write);
        logic [7:0] d;
        if (do_write) bus_wr(ADR_PORT, 8'hFF);
        else begin
            bus_rd(ADR_PORT, d);
            chk("R6 port read", d, {2'b0, m_pins});
        end
        m_snap = m_pins;
        cycles(3);
    endtask

    task automatic clear_flag();
        bus_wr(ADR_CTRL, {6'b0, m_gate, 1'b0});
        m_flag = diff_now();
        cycles(3);
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1C0C));
        pin_i = 6'h2D; m_pins = 6'h2D; m_snap = 6'h2D;
        cycles(5);
        rst = 1'b0;
        cycles(2);

        // R3 reset state
        bus_rd(ADR_MASK, d);  chk("R3 mask reset", d, 8'h00);
        check_outs("R3 reset");
        bus_wr(ADR_MASK, 8'h3F); m_mask = 6'h3F; cycles(4);
        check_outs("R3 no spurious flag");

        // R2 upper bits read zero
        bus_wr(ADR_MASK, 8'hC5); m_mask = 6'h05;
        bus_rd(ADR_MASK, d); chk("R2 mask readback", d, 8'h05);

        // R4 latency: change before edge, flag visible after third edge
        @(negedge clk);
        pin_i = m_pins ^ 6'h01; m_pins = pin_i;
        @(negedge clk); @(negedge clk);
        chk("R4 not after two edges", wake_o, 1'b0);
        @(negedge clk);
        chk("R4 set after three edges", wake_o, 1'b1);
        m_flag = 1'b1;
        cycles(2);

        // R5 clear while difference persists is ignored
        clear_flag();
        check_outs("R5 sticky clear");
        // R8 pins return: flag stays
        set_pins(m_snap);
        check_outs("R8 hold after return");
        // R7 write 1 to flag bit does not set
        port_access(1'b0);
        clear_flag();
        check_outs("R7 cleared");
        bus_wr(ADR_CTRL, 8'h01); cycles(2);
        check_outs("R7 write one no set");

        // R1 masked-out pin ignored
        set_pins(m_pins ^ 6'h02);
        check_outs("R1 masked pin ignored");

        // R10 / R9 gate
        bus_wr(ADR_CTRL, 8'h02); m_gate = 1'b1;
        set_pins(m_pins ^ 6'h04);
        check_outs("R10 gated irq");
        bus_wr(ADR_CTRL, 8'h00); m_gate = 1'b0; m_flag = diff_now(); cycles(2);
        check_outs("R9 wake without gate");
        port_access(1'b1);
        clear_flag();
        check_outs("R6 port write snapshot");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0, 1: set_pins(6'($urandom));
                2: port_access(1'($urandom));
                3: clear_flag();
                4: begin
                    logic [7:0] mv = 8'($urandom);
                    bus_wr(ADR_MASK, mv); m_mask = mv[5:0];
                    cycles(4);
                    m_flag = m_flag | diff_now();
                    bus_rd(ADR_MASK, d); chk("R2 random mask", d, {2'b0, m_mask});
                end
                default: begin
                    logic gv = 1'($urandom);
                    bus_wr(ADR_CTRL, {6'b0, gv, 1'b1}); m_gate = gv;
                    cycles(2);
                end
            endcase
            check_outs("R5 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule